// File: doc/BRIEF.md
# Board Control and Timebase Register Bank

This block is a small 32-bit register bank that sits on a simple single-cycle memory-mapped bus inside a 4 KB window. Software uses it to drive two status LEDs, sample push buttons, and keep a miscellaneous control word whose bits are wired out to other board logic. It also keeps two free-running timebases, one advancing once per second and one advancing a hundred times per second.

Both timebases are derived from the system clock with a fractional phase accumulator, so the rate averages out exactly for any system clock frequency given as a parameter. Software can read either timebase at any time. It can also overwrite it: counting then continues from the written value, starting a fresh tick period.

A separate prescaled event counter block owns three registers that live in this window. This bank routes reads of those offsets to that block's current values. It forwards writes to them as a one-cycle select strobe with the bus write data. Read data is registered and appears in the cycle after the access. Reads never change any state.

Top module: `board_ctrl_regs`

## Requirements
- R1: After reset, the LED outputs, the control word output, the read data, and both timebase counts are zero.
- R2: A write to byte offset 0x000 stores write-data bits [1:0] only; bit 0 drives `led_o[0]` and bit 1 drives `led_o[1]`. A read of 0x000 returns those two bits with zeros above them. No other access changes the LEDs.
- R3: The slow timebase at offset 0x010 advances by one every SYS_CLK_HZ clock cycles.
- R4: The fast timebase at offset 0x014 advances by one each time a further SYS_CLK_HZ/100 cycles have elapsed on average, counting up from its start point. Counts wrap modulo 2^32.
- R5: A write to either timebase sets its count to the written value and restarts its tick phase. The next increment then follows a full tick period after the write cycle, and the write takes precedence over a coinciding tick.
- R6: Offset 0x04C holds a 32-bit control word that reads back the last value written and drives `misc_o`.
- R7: Reads of offsets 0x018, 0x01C and 0x020 return `evt_count_i`, `evt_reload_i` and `evt_current_i`. A write to one of these offsets raises `evt_wr_o` bit 0, 1 or 2 respectively, for that access cycle only, with `evt_wdata_o` equal to the write data. No more than one bit is ever high.
- R8: A read of offset 0x008 returns `btn_i` after a two-stage synchroniser, in the low BTN_W bits, with zeros above them. Writes to 0x008 have no effect.
- R9: Every other offset is unmapped, and so is any address with bits [1:0] not zero. Reads of an unmapped address return zero. Writes to one change no register and raise no strobe.
- R10: Read data appears on `bus_rdata_o` in the cycle after a read access. It holds its value until the next read access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel_i | input | 1 | Access valid this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte address within the window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| led_o | output | 2 | LED drive |
| btn_i | input | BTN_W | Asynchronous button inputs |
| misc_o | output | 32 | Control word |
| evt_wr_o | output | 3 | Write strobes to event counter registers (count, reload, current) |
| evt_wdata_o | output | 32 | Write data to the event counter |
| evt_count_i | input | 32 | Event counter total |
| evt_reload_i | input | 32 | Event counter reload value |
| evt_current_i | input | 32 | Event counter current prescale count |

## Verification
The timebases are tried with directed reloads read back one cycle before and exactly at a tick boundary. This tells a correct period apart from an off-by-one. A second reload partway through a period tells a cleared phase apart from a kept one, and a reload of all ones checks the wrap. A seeded random mix of reads and writes over mapped, unmapped and misaligned addresses compares every read and every strobe against a bench model. This separates correct decoding from aliasing, and stored bits from masked ones. Button reads after an input change check the synchroniser latency, and idle cycles after a read check that the read data holds.

// File: rtl/bc_pkg.sv
package bc_pkg;
  localparam int unsigned WIN_AW = 12;
  localparam int unsigned IDX_W  = WIN_AW - 2;

  localparam logic [IDX_W-1:0] IDX_LED   = 10'h000;
  localparam logic [IDX_W-1:0] IDX_BTN   = 10'h002;
  localparam logic [IDX_W-1:0] IDX_TB0   = 10'h004;
  localparam logic [IDX_W-1:0] IDX_EVCNT = 10'h006;
  localparam logic [IDX_W-1:0] IDX_EVRLD = 10'h007;
  localparam logic [IDX_W-1:0] IDX_EVCUR = 10'h008;
  localparam logic [IDX_W-1:0] IDX_MISC  = 10'h013;

  localparam int unsigned TB_N = 2;
  localparam int unsigned EV_N = 3;

  typedef enum logic [1:0] {
    EV_COUNT   = 2'd0,
    EV_RELOAD  = 2'd1,
    EV_CURRENT = 2'd2
  } ev_sel_e;

  function automatic int unsigned tb_rate(input int unsigned g);
    return (g == 0) ? 1 : 100;
  endfunction
endpackage

// File: rtl/bc_sync.sv
module bc_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = d_i;
    for (int s = 1; s < STAGES; s++) stage_d[s] = stage_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= stage_d[s];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/bc_timebase.sv
module bc_timebase #(
  parameter int unsigned SYS_HZ  = 2000,
  parameter int unsigned RATE_HZ = 1,
  parameter int unsigned CNT_W   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] count_o
);
  localparam int unsigned ACC_W = $clog2(SYS_HZ + RATE_HZ + 1);
  localparam logic [ACC_W-1:0] STEP = ACC_W'(RATE_HZ);
  localparam logic [ACC_W-1:0] WRAP = ACC_W'(SYS_HZ);

  logic [ACC_W-1:0] acc_q, acc_d, acc_sum;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tick, cnt_en;

  always_comb begin
    acc_sum = acc_q + STEP;
    tick    = (acc_sum >= WRAP);
    cnt_en  = load_i | tick;
    if (load_i) begin
      acc_d = '0;
      cnt_d = load_val_i;
    end else if (tick) begin
      acc_d = acc_sum - WRAP;
      cnt_d = cnt_q + CNT_W'(1);
    end else begin
      acc_d = acc_sum;
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load_i) |-> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CNT_W'(1)));

  assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load_i) |-> cnt_q == $past(load_val_i));
endmodule

// File: rtl/board_ctrl_regs.sv
module board_ctrl_regs
  import bc_pkg::*;
#(
  parameter int unsigned SYS_CLK_HZ = 2000,
  parameter int unsigned BTN_W      = 2,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned LED_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [WIN_AW-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic [LED_W-1:0]  led_o,
  input  logic [BTN_W-1:0]  btn_i,
  output logic [DATA_W-1:0] misc_o,
  output logic [EV_N-1:0]   evt_wr_o,
  output logic [DATA_W-1:0] evt_wdata_o,
  input  logic [DATA_W-1:0] evt_count_i,
  input  logic [DATA_W-1:0] evt_reload_i,
  input  logic [DATA_W-1:0] evt_current_i
);
  logic              rst_i;
  logic [BTN_W-1:0]  btn_s;
  logic [IDX_W-1:0]  idx;
  logic              aligned, wr, rd, hit, rd_miss;
  logic              led_we, misc_we;
  logic [LED_W-1:0]  led_q, led_d;
  logic [DATA_W-1:0] misc_q, misc_d;
  logic [DATA_W-1:0] rd_val, rdata_q;
  logic [DATA_W-1:0] tb_cnt [TB_N];

  bc_sync #(.W(1), .STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d_i(1'b1), .q_o(rst_i)
  );

  bc_sync #(.W(BTN_W), .STAGES(2)) u_btn_sync (
    .clk(clk), .rst_n(rst_i), .d_i(btn_i), .q_o(btn_s)
  );

  // Address decode
  always_comb begin
    idx     = bus_addr_i[WIN_AW-1:2];
    aligned = (bus_addr_i[1:0] == 2'b00);
    wr      = bus_sel_i & bus_we_i & aligned;
    rd      = bus_sel_i & ~bus_we_i;
    led_we  = wr && (idx == IDX_LED);
    misc_we = wr && (idx == IDX_MISC);
    evt_wr_o = '0;
    evt_wr_o[EV_COUNT]   = wr && (idx == IDX_EVCNT);
    evt_wr_o[EV_RELOAD]  = wr && (idx == IDX_EVRLD);
    evt_wr_o[EV_CURRENT] = wr && (idx == IDX_EVCUR);
  end

  assign evt_wdata_o = bus_wdata_i;

  // Timebases
  for (genvar g = 0; g < TB_N; g++) begin : g_tb
    localparam logic [IDX_W-1:0] MY_IDX = IDX_TB0 + IDX_W'(g);
    logic load;
    assign load = wr && (idx == MY_IDX);
    bc_timebase #(
      .SYS_HZ(SYS_CLK_HZ), .RATE_HZ(tb_rate(g)), .CNT_W(DATA_W)
    ) u_tb (
      .clk(clk), .rst_n(rst_i), .load_i(load),
      .load_val_i(bus_wdata_i), .count_o(tb_cnt[g])
    );
  end

  // Read mux
  always_comb begin
    hit    = aligned;
    rd_val = '0;
    case (idx)
      IDX_LED:         rd_val[LED_W-1:0] = led_q;
      IDX_BTN:         rd_val[BTN_W-1:0] = btn_s;
      IDX_TB0:         rd_val = tb_cnt[0];
      IDX_TB0 + 10'd1: rd_val = tb_cnt[1];
      IDX_EVCNT:       rd_val = evt_count_i;
      IDX_EVRLD:       rd_val = evt_reload_i;
      IDX_EVCUR:       rd_val = evt_current_i;
      IDX_MISC:        rd_val = misc_q;
      default:         hit = 1'b0;
    endcase
    if (!aligned) rd_val = '0;
    rd_miss = rd & ~hit;
  end

  // Next state
  always_comb begin
    led_d  = bus_wdata_i[LED_W-1:0];
    misc_d = bus_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i)      led_q <= '0;
    else if (led_we) led_q <= led_d;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i)       misc_q <= '0;
    else if (misc_we) misc_q <= misc_d;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i)  rdata_q <= '0;
    else if (rd) rdata_q <= rd_val;
  end

  assign led_o       = led_q;
  assign misc_o      = misc_q;
  assign bus_rdata_o = rdata_q;

  assert_led_hold_R2: assert property (@(posedge clk) disable iff (!rst_i)
    !$past(led_we) |-> $stable(led_o));

  assert_misc_store_R6: assert property (@(posedge clk) disable iff (!rst_i)
    $past(misc_we) |-> misc_o == $past(bus_wdata_i));

  assert_evt_onehot_R7: assert property (@(posedge clk) disable iff (!rst_i)
    $onehot0(evt_wr_o));

  assert_unmapped_rd_R9: assert property (@(posedge clk) disable iff (!rst_i)
    $past(rd_miss) |-> bus_rdata_o == '0);

  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_i)
    !$past(rd) |-> $stable(bus_rdata_o));
endmodule

// File: tb/board_ctrl_regs_tb_top.sv
module board_ctrl_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SYS        = 2000;
  localparam int BW         = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sel, we;
  logic [11:0] addr;
  logic [31:0] wdata, rdata, misc, evwd, ev_cnt, ev_rld, ev_cur;
  logic [1:0]  led;
  logic [BW-1:0] btn;
  logic [2:0]  evwr;

  int  n_chk = 0;
  int  n_err = 0;
  longint cyc = 0;
  bit  done = 0;

  // Bench model
  logic [1:0]  led_m;
  logic [31:0] misc_m;
  logic [31:0] tb_base [2];
  longint      tb_cw [2];
  logic [BW-1:0] btn_m;

  board_ctrl_regs #(.SYS_CLK_HZ(SYS), .BTN_W(BW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .led_o(led), .btn_i(btn), .misc_o(misc), .evt_wr_o(evwr),
    .evt_wdata_o(evwd), .evt_count_i(ev_cnt), .evt_reload_i(ev_rld),
    .evt_current_i(ev_cur)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] tb_exp(input int g, input longint cr);
    longint n = cr - tb_cw[g] - 1;
    longint rate = (g == 0) ? 1 : 100;
    return tb_base[g] + 32'((n * rate) / SYS);
  endfunction

  function automatic logic [31:0] rd_exp(input logic [11:0] a, input longint cr);
    case (a)
      12'h000: return {30'd0, led_m};
      12'h008: return {{(32-BW){1'b0}}, btn_m};
      12'h010: return tb_exp(0, cr);
      12'h014: return tb_exp(1, cr);
      12'h018: return ev_cnt;
      12'h01C: return ev_rld;
      12'h020: return ev_cur;
      12'h04C: return misc_m;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [2:0] strobe_exp(input logic [11:0] a);
    case (a)
      12'h018: return 3'b001;
      12'h01C: return 3'b010;
      12'h020: return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  // One bus access, called at a negedge; returns at the following negedge.
  task automatic acc(input logic [11:0] a, input bit w, input logic [31:0] d,
                     input string req);
    longint c = cyc;
    sel = 1'b1; we = w; addr = a; wdata = d;
    #1;
    if (w) begin
      chk({req, " strobe"}, {29'd0, evwr}, {29'd0, strobe_exp(a)});
      if (evwr != 3'b000) chk({req, " wdata"}, evwd, d);
    end
    @(posedge clk);
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
    if (w) begin
      case (a)
        12'h000: led_m  = d[1:0];
        12'h04C: misc_m = d;
        12'h010: begin tb_base[0] = d; tb_cw[0] = c; end
        12'h014: begin tb_base[1] = d; tb_cw[1] = c; end
        default: ;
      endcase
    end else begin
      chk(req, rdata, rd_exp(a, c));
    end
  endtask

  task automatic wait_until(input longint target);
    while (cyc < target) @(negedge clk);
  endtask

  initial begin
    logic [11:0] offs [14];
    longint c0, cw;
    logic [31:0] keep;
    offs = '{12'h000, 12'h008, 12'h010, 12'h014, 12'h018, 12'h01C, 12'h020,
             12'h04C, 12'h004, 12'h024, 12'h050, 12'hFFC, 12'h002, 12'h04D};
    void'($urandom(32'h5EED));
    rst_n = 1'b0; sel = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    btn = '0; btn_m = '0;
    ev_cnt = $urandom; ev_rld = $urandom; ev_cur = $urandom;
    led_m = '0; misc_m = '0;
    tb_base[0] = '0; tb_base[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    c0 = cyc;
    tb_cw[0] = c0 + 1; tb_cw[1] = c0 + 1;
    repeat (3) @(negedge clk);

    // R1: reset values
    chk("R1 led", {30'd0, led}, 32'h0);
    chk("R1 misc", misc, 32'h0);
    chk("R1 rdata", rdata, 32'h0);
    acc(12'h010, 0, 0, "R1 tb slow");
    acc(12'h014, 0, 0, "R1 tb fast");
    acc(12'h04C, 0, 0, "R1 misc rd");

    // R2: LED keeps only two bits
    acc(12'h000, 1, 32'hFFFF_FFFF, "R2");
    chk("R2 led_o", {30'd0, led}, 32'h3);
    acc(12'h000, 0, 0, "R2 rd");
    acc(12'h000, 1, 32'h0000_0002, "R2");
    chk("R2 led_o", {30'd0, led}, 32'h2);

    // R6: control word
    acc(12'h04C, 1, 32'hA5C3_0F1E, "R6");
    chk("R6 misc_o", misc, 32'hA5C3_0F1E);
    acc(12'h04C, 0, 0, "R6 rd");

    // R10: read data holds through idle cycles and writes
    keep = rdata;
    repeat (3) @(negedge clk);
    acc(12'h000, 1, 32'h1, "R10 wr");
    chk("R10 hold", rdata, keep);

    // R4 / R5: fast timebase boundary and phase clear
    cw = cyc;
    acc(12'h014, 1, 32'h0000_0100, "R5");
    wait_until(cw + 16);
    cw = cyc;
    acc(12'h014, 1, 32'h0000_0200, "R5");
    wait_until(cw + 20);
    acc(12'h014, 0, 0, "R5 phase cleared");
    acc(12'h014, 0, 0, "R4 boundary");
    chk("R4 value", rdata, 32'h0000_0201);
    cw = cyc;
    acc(12'h014, 1, 32'hFFFF_FFFF, "R4 wrap");
    wait_until(cw + 30);
    acc(12'h014, 0, 0, "R4 wrap");
    chk("R4 wrapped", rdata, 32'h0);

    // R3: slow timebase boundary
    cw = cyc;
    acc(12'h010, 1, 32'h7, "R3");
    wait_until(cw + 2000);
    acc(12'h010, 0, 0, "R3 before");
    chk("R3 before", rdata, 32'h7);
    acc(12'h010, 0, 0, "R3 at");
    chk("R3 at", rdata, 32'h8);

    // R8: buttons, synchronised, writes ignored
    btn = 2'b10; btn_m = 2'b10;
    repeat (3) @(negedge clk);
    acc(12'h008, 0, 0, "R8");
    acc(12'h008, 1, 32'hFFFF_FFFF, "R8 wr");
    acc(12'h008, 0, 0, "R8 after wr");

    // R7: event counter pass-through
    acc(12'h018, 0, 0, "R7 count");
    acc(12'h01C, 0, 0, "R7 reload");
    acc(12'h020, 0, 0, "R7 current");
    acc(12'h01C, 1, 32'hDEAD_0001, "R7");
    acc(12'h020, 1, 32'h0BAD_F00D, "R7");

    // R9: unmapped and misaligned addresses
    for (int i = 8; i < 14; i++) acc(offs[i], 1, 32'hFFFF_FFFF, "R9 wr");
    for (int i = 8; i < 14; i++) acc(offs[i], 0, 0, "R9 rd");
    chk("R9 led", {30'd0, led}, {30'd0, led_m});
    chk("R9 misc", misc, misc_m);
    acc(12'h04C, 0, 0, "R9 misc intact");

    // Random mix
    for (int i = 0; i < 400; i++) begin
      int k = $urandom_range(0, 13);
      bit w = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 7) == 0) begin
        ev_cnt = $urandom; ev_rld = $urandom; ev_cur = $urandom;
      end
      acc(offs[k], w, $urandom, "R9 random");
      if ($urandom_range(0, 3) == 0) repeat ($urandom_range(1, 30)) @(negedge clk);
    end
    chk("R2 final", {30'd0, led}, {30'd0, led_m});
    chk("R6 final", misc, misc_m);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule